// File: doc/BRIEF.md
# Two-Epoch Speculative Line Controller

This block keeps the tag-side state of a set-associative write-back data cache that holds speculative data from two live checkpoint epochs at the same time. Each line carries a valid bit, a dirty bit, a tag and a two-bit epoch field. For every processor access the controller looks up the addressed set and decides four things. It picks the new state of the line. It flags a write-back to memory. It chooses a victim way on a miss. It decides whether the older epoch must be committed before the access can go ahead.

The controller also keeps a line count for each epoch identifier and tracks which identifier is current and which is older. When a commit is needed, it raises a request to an external tag-walk engine and holds it until that engine acknowledges. It then clears the epoch fields of the committed identifier, either alone or together with the other one. While a commit is pending the access port is not ready, and the requester holds its access until it is accepted. One whole epoch therefore always stays available for rollback, except after a system event.

Top module: `ckpt_epoch_ctrl`

## Requirements
- R1: Epoch field encoding: 2'b00 is committed data, 2'b01 and 2'b10 are the two speculative epochs, and 2'b11 never occurs. After reset the current identifier is 2'b01 and the older one is 2'b10. The response reports the line's epoch field after the access.
- R2: Only a valid line with its dirty bit set holds a nonzero epoch field. A write-back is flagged only for a valid dirty line.
- R3: A read hit changes nothing: no write-back, and the reported epoch is the line's existing field. A read miss fills the victim way as clean with epoch 2'b00.
- R4: A write miss fills the victim way. A write hit on a committed line first writes it back if it is dirty. In both cases the line becomes dirty, is tagged with the current identifier, and that identifier's line count rises by one.
- R5: A write hit on a line of the current epoch marks the line dirty. It flags no write-back and leaves the epoch field unchanged.
- R6: A write hit on a line of the older epoch first commits the older identifier. The identifier just freed becomes current and the previous current becomes the older one. The access then writes the line back and tags it with the new current identifier.
- R7: When the current identifier's line count reaches half the total line count, the older identifier is committed and the two identifiers swap roles.
- R8: A speculative line is never a victim. The victim is the lowest-numbered invalid way if one exists. Otherwise it is the first committed way found by searching upward, with wrap-around, from a per-set pointer; that pointer then moves to the way after the victim.
- R9: A miss in a set whose ways are all speculative first commits the older identifier, then evicts one of the lines just committed.
- R10: One identifier owns at most WAYS/2 ways of a set. A write that would need another line for the current identifier in a set already at that limit first commits the older identifier.
- R11: A one-cycle pulse on `sys_evt` leads to a single commit of both identifiers (`commit_id` 2'b11). Both line counts return to zero and the identifiers keep their roles.
- R12: `commit_req` stays high with a stable `commit_id` until `commit_ack`, and `acc_ready` is low meanwhile. An accepted access produces its response on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Access accepted this cycle when high together with acc_valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_set | input | $clog2(SETS) | Set index |
| acc_tag | input | TAG_W | Address tag |
| sys_evt | input | 1 | Pulse: I/O or system call, commit both epochs |
| commit_req | output | 1 | Commit request to the tag-walk engine |
| commit_id | output | 2 | Identifiers to commit (01, 10 or 11) |
| commit_ack | input | 1 | Tag-walk engine has finished the commit |
| resp_valid | output | 1 | Response for the access accepted on the previous edge |
| resp_hit | output | 1 | Access hit |
| resp_way | output | $clog2(WAYS) | Way that was hit or filled |
| resp_wb | output | 1 | Write-back of a dirty line required |
| resp_wb_tag | output | TAG_W | Tag of the line to write back |
| resp_epoch | output | 2 | Epoch field of the line after the access |
| cur_epoch | output | 2 | Current epoch identifier |
| old_epoch | output | 2 | Older epoch identifier |

## Verification
The bench builds the controller with four sets, four ways and four-bit tags. That gives sixteen lines, a count threshold of eight and a per-set limit of two ways. Every commit cause is then reachable within a handful of accesses: the set limit, a write to an older-epoch line, a fully speculative set, the count threshold and the system event. A directed sweep walks each cause and the victim pointer wrap. A long pseudo-random stream over eight tags then compares every response field, commit identifier and identifier swap against a reference model kept in the bench.

// File: rtl/ckpt_pkg.sv
// Shared encodings for the two-epoch speculative line controller.
// Assumes epoch identifiers are one-hot so that a commit mask of 2'b11
// names both speculative epochs at once.
package ckpt_pkg;
    localparam logic [1:0] EP_NONE = 2'b00;
    localparam logic [1:0] EP_A    = 2'b01;
    localparam logic [1:0] EP_B    = 2'b10;
    localparam logic [1:0] EP_BOTH = 2'b11;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_COMMIT = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/ckpt_way_scan.sv
// Per-set lookup: tag match, ownership count for the current epoch and
// the speculative-way vector. Purely combinational.
// Assumes at most one valid way of a set matches a given tag.
module ckpt_way_scan #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0]            line_v,
    input  logic [WAYS-1:0][TAG_W-1:0] line_t,
    input  logic [WAYS-1:0][1:0]       line_e,
    input  logic [TAG_W-1:0]           probe_tag,
    input  logic [1:0]                 cur_id,
    output logic                       hit,
    output logic [$clog2(WAYS)-1:0]    hit_way,
    output logic [$clog2(WAYS+1)-1:0]  cur_own,
    output logic [WAYS-1:0]            spec_vec
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OWN_W = $clog2(WAYS + 1);

    logic [WAYS-1:0] match;
    logic [WAYS-1:0] own_bit;

    // Per-way compare cells.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign match[g]    = line_v[g] && (line_t[g] == probe_tag);
        assign own_bit[g]  = (line_e[g] == cur_id);
        assign spec_vec[g] = (line_e[g] != 2'b00);
    end

    // Encode the matching way and count current-epoch ownership.
    always_comb begin
        hit_way = '0;
        cur_own = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) hit_way = WAY_W'(i);
            cur_own = cur_own + OWN_W'(own_bit[i]);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/ckpt_victim_sel.sv
// Victim choice for a miss: lowest invalid way first, otherwise the first
// nonspeculative way searched upward from the set's round-robin pointer.
// Assumes invalid ways carry epoch 00, so they are never flagged speculative.
module ckpt_victim_sel #(
    parameter int WAYS = 8
) (
    input  logic [WAYS-1:0]         line_v,
    input  logic [WAYS-1:0]         spec_vec,
    input  logic [$clog2(WAYS)-1:0] rr_ptr,
    output logic                    vict_ok,
    output logic                    vict_rr,
    output logic [$clog2(WAYS)-1:0] vict_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic                free_found;
    logic [WAY_W-1:0]    free_way;
    logic                rr_found;
    logic [WAY_W-1:0]    rr_way;

    // Lowest-numbered invalid way.
    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!line_v[i]) begin
                free_found = 1'b1;
                free_way   = WAY_W'(i);
            end
        end
    end

    // First committed way at or after the pointer, wrapping around.
    always_comb begin
        rr_found = 1'b0;
        rr_way   = '0;
        for (int i = 0; i < WAYS; i++) begin
            int j;
            j = (int'(rr_ptr) + i) % WAYS;
            if (!rr_found && !spec_vec[j]) begin
                rr_found = 1'b1;
                rr_way   = WAY_W'(j);
            end
        end
    end

    // Final choice.
    always_comb begin
        vict_ok  = free_found || rr_found;
        vict_rr  = !free_found && rr_found;
        vict_way = free_found ? free_way : rr_way;
    end
endmodule

// File: rtl/ckpt_epoch_track.sv
// Tracks which identifier is current and which is older, plus a line count
// per identifier. An applied commit clears the counts of the committed
// identifiers; a single-identifier commit also swaps roles so the freed
// identifier is reused for the new epoch.
module ckpt_epoch_track #(
    parameter int LINES = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc,
    input  logic                        apply,
    input  logic [1:0]                  mask,
    output logic [1:0]                  cur_id,
    output logic [1:0]                  old_id,
    output logic [$clog2(LINES+1)-1:0]  cur_cnt,
    output logic                        thr_hit
);
    import ckpt_pkg::*;

    localparam int CNT_W = $clog2(LINES + 1);
    localparam int HALF  = LINES / 2;

    logic [1:0]       cur_q;
    logic [1:0]       old_q;
    logic [CNT_W-1:0] cnt_q [2];

    // Role and count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= EP_A;
            old_q    <= EP_B;
            cnt_q[0] <= '0;
            cnt_q[1] <= '0;
        end else if (apply) begin
            if (mask[0]) cnt_q[0] <= '0;
            if (mask[1]) cnt_q[1] <= '0;
            if (mask != EP_BOTH) begin
                cur_q <= old_q;
                old_q <= cur_q;
            end
        end else if (inc) begin
            cnt_q[cur_q[1]] <= cnt_q[cur_q[1]] + 1'b1;
        end
    end

    assign cur_id  = cur_q;
    assign old_id  = old_q;
    assign cur_cnt = cnt_q[cur_q[1]];
    assign thr_hit = (cnt_q[cur_q[1]] >= CNT_W'(HALF));

    // R1: identifiers stay the two distinct speculative codes.
    a_r1_id_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cur_q) && $onehot(old_q) && (cur_q != old_q));

    // R7: the threshold commit keeps every count at or below half the lines.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[0] <= CNT_W'(HALF)) && (cnt_q[1] <= CNT_W'(HALF)));

    // R11: a commit of both identifiers leaves the roles in place.
    a_r11_both_keeps_roles: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && mask == EP_BOTH) |=> $stable(cur_q) && (cur_cnt == '0));
endmodule

// File: rtl/ckpt_epoch_ctrl.sv
// Top of the two-epoch speculative line controller. Holds the tag store
// (valid, dirty, tag, epoch per line, round-robin pointer per set), runs the
// commit handshake with an external tag-walk engine and decides, per access,
// fill, write-back, victim and epoch tagging.
// Assumes WAYS is a power of two and at least 2, SETS is at least 2, and the
// requester holds an access stable until acc_ready accepts it.
module ckpt_epoch_ctrl #(
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    output logic                     acc_ready,
    input  logic                     acc_write,
    input  logic [$clog2(SETS)-1:0]  acc_set,
    input  logic [TAG_W-1:0]         acc_tag,
    input  logic                     sys_evt,
    output logic                     commit_req,
    output logic [1:0]               commit_id,
    input  logic                     commit_ack,
    output logic                     resp_valid,
    output logic                     resp_hit,
    output logic [$clog2(WAYS)-1:0]  resp_way,
    output logic                     resp_wb,
    output logic [TAG_W-1:0]         resp_wb_tag,
    output logic [1:0]               resp_epoch,
    output logic [1:0]               cur_epoch,
    output logic [1:0]               old_epoch
);
    import ckpt_pkg::*;

    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OWN_W = $clog2(WAYS + 1);
    localparam int LINES = SETS * WAYS;
    localparam int CNT_W = $clog2(LINES + 1);
    localparam int CAP   = WAYS / 2;

    // Tag store.
    logic [WAYS-1:0]            v_q  [SETS];
    logic [WAYS-1:0]            d_q  [SETS];
    logic [WAYS-1:0][1:0]       e_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0] t_q  [SETS];
    logic [WAY_W-1:0]           rr_q [SETS];

    ctl_state_t state_q;
    logic [1:0] cid_q;
    logic       sys_pend_q;

    logic [1:0]       cur_id, old_id;
    logic [CNT_W-1:0] cur_cnt;
    logic             thr_hit;

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [OWN_W-1:0] cur_own;
    logic [WAYS-1:0]  spec_vec;
    logic             vict_ok, vict_rr;
    logic [WAY_W-1:0] vict_way;

    logic [1:0] hit_ep;
    logic       hit_dirty;
    logic       acc_need;
    logic [1:0] need_mask;
    logic       fire, apply, cnt_inc;
    logic [WAY_W-1:0] rr_next;

    ckpt_way_scan #(.WAYS(WAYS), .TAG_W(TAG_W)) u_scan (
        .line_v    (v_q[acc_set]),
        .line_t    (t_q[acc_set]),
        .line_e    (e_q[acc_set]),
        .probe_tag (acc_tag),
        .cur_id    (cur_id),
        .hit       (hit),
        .hit_way   (hit_way),
        .cur_own   (cur_own),
        .spec_vec  (spec_vec)
    );

    ckpt_victim_sel #(.WAYS(WAYS)) u_vict (
        .line_v   (v_q[acc_set]),
        .spec_vec (spec_vec),
        .rr_ptr   (rr_q[acc_set]),
        .vict_ok  (vict_ok),
        .vict_rr  (vict_rr),
        .vict_way (vict_way)
    );

    ckpt_epoch_track #(.LINES(LINES)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .apply   (apply),
        .mask    (cid_q),
        .cur_id  (cur_id),
        .old_id  (old_id),
        .cur_cnt (cur_cnt),
        .thr_hit (thr_hit)
    );

    assign hit_ep    = e_q[acc_set][hit_way];
    assign hit_dirty = d_q[acc_set][hit_way];

    // Does the presented access need the older epoch committed first?
    always_comb begin
        acc_need = 1'b0;
        if (acc_valid) begin
            if (!acc_write) begin
                acc_need = !hit && !vict_ok;
            end else if (hit) begin
                acc_need = (hit_ep == old_id) ||
                           ((hit_ep == EP_NONE) && (cur_own >= OWN_W'(CAP)));
            end else begin
                acc_need = (cur_own >= OWN_W'(CAP)) || !vict_ok;
            end
        end
    end

    // Commit cause priority: system event, count threshold, access.
    always_comb begin
        if (sys_pend_q)                need_mask = EP_BOTH;
        else if (thr_hit || acc_need)  need_mask = old_id;
        else                           need_mask = EP_NONE;
    end

    assign acc_ready  = (state_q == ST_RUN) && (need_mask == EP_NONE);
    assign fire       = acc_valid && acc_ready;
    assign apply      = (state_q == ST_COMMIT) && commit_ack;
    assign cnt_inc    = fire && acc_write && (!hit || hit_ep == EP_NONE);
    assign rr_next    = (vict_way == WAY_W'(WAYS - 1)) ? '0 : vict_way + 1'b1;
    assign commit_req = (state_q == ST_COMMIT);
    assign commit_id  = cid_q;
    assign cur_epoch  = cur_id;
    assign old_epoch  = old_id;

    // Commit handshake state and pending system event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            cid_q      <= EP_NONE;
            sys_pend_q <= 1'b0;
        end else begin
            sys_pend_q <= sys_evt ||
                          (sys_pend_q && !(state_q == ST_RUN && need_mask == EP_BOTH));
            if (state_q == ST_RUN) begin
                if (need_mask != EP_NONE) begin
                    state_q <= ST_COMMIT;
                    cid_q   <= need_mask;
                end
            end else if (commit_ack) begin
                state_q <= ST_RUN;
            end
        end
    end

    // Line state: commit clearing and per-access update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                v_q[s]  <= '0;
                d_q[s]  <= '0;
                e_q[s]  <= '0;
                rr_q[s] <= '0;
            end
        end else if (apply) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if ((e_q[s][w] & cid_q) != 2'b00) e_q[s][w] <= EP_NONE;
                end
            end
        end else if (fire) begin
            if (hit) begin
                if (acc_write) begin
                    d_q[acc_set][hit_way] <= 1'b1;
                    e_q[acc_set][hit_way] <= cur_id;
                end
            end else begin
                v_q[acc_set][vict_way] <= 1'b1;
                d_q[acc_set][vict_way] <= acc_write;
                e_q[acc_set][vict_way] <= acc_write ? cur_id : EP_NONE;
                if (vict_rr) rr_q[acc_set] <= rr_next;
            end
        end
    end

    // Tag field fill on a miss.
    always_ff @(posedge clk) begin
        if (fire && !hit) t_q[acc_set][vict_way] <= acc_tag;
    end

    // Registered response, one edge after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_way    <= '0;
            resp_wb     <= 1'b0;
            resp_wb_tag <= '0;
            resp_epoch  <= EP_NONE;
        end else begin
            resp_valid <= fire;
            if (fire) begin
                resp_hit <= hit;
                resp_way <= hit ? hit_way : vict_way;
                if (hit) begin
                    resp_wb     <= acc_write && (hit_ep == EP_NONE) && hit_dirty;
                    resp_wb_tag <= acc_tag;
                    resp_epoch  <= acc_write ? cur_id : hit_ep;
                end else begin
                    resp_wb     <= v_q[acc_set][vict_way] && d_q[acc_set][vict_way];
                    resp_wb_tag <= t_q[acc_set][vict_way];
                    resp_epoch  <= acc_write ? cur_id : EP_NONE;
                end
            end
        end
    end

    // Per-set ownership of one identifier.
    function automatic int own_count(input logic [WAYS-1:0][1:0] e, input logic [1:0] id);
        int n;
        n = 0;
        for (int w = 0; w < WAYS; w++) if (e[w] == id) n++;
        return n;
    endfunction

    for (genvar gs = 0; gs < SETS; gs++) begin : g_set_chk
        // R10: neither identifier owns more than half the ways of a set.
        a_r10_set_cap: assert property (@(posedge clk) disable iff (!rst_n)
            (own_count(e_q[gs], EP_A) <= CAP) && (own_count(e_q[gs], EP_B) <= CAP));
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_way_chk
            // R1 and R2: no code 11; a speculative line is valid and dirty.
            a_r2_spec_dirty: assert property (@(posedge clk) disable iff (!rst_n)
                (e_q[gs][gw] != EP_NONE) |-> (v_q[gs][gw] && d_q[gs][gw] &&
                                              e_q[gs][gw] != EP_BOTH));
        end
    end

    // R8: a miss only proceeds with a committed victim way.
    a_r8_no_spec_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hit) |-> (e_q[acc_set][vict_way] == EP_NONE));

    // R3: a read hit leaves the line's epoch field as it was.
    a_r3_read_keeps_epoch: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !acc_write && hit) |=>
            (e_q[$past(acc_set)][$past(hit_way)] == $past(hit_ep)));

    // R12: the request holds with a stable identifier until acknowledged.
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_ack) |=> (commit_req && $stable(commit_id)));

    // R12: no access is accepted while a commit is pending.
    a_r12_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> !acc_ready);
endmodule

// File: tb/ckpt_epoch_ctrl_tb.sv
// Self-checking bench: reference model of the tag store built from the
// requirements, directed sweeps of every commit cause, then a long
// pseudo-random access stream.
module ckpt_epoch_ctrl_tb;
    localparam int S  = 4;
    localparam int W  = 4;
    localparam int TW = 4;
    localparam int HALF = S * W / 2;
    localparam int CAP  = W / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic acc_ready;
    logic acc_write = 1'b0;
    logic [1:0] acc_set = '0;
    logic [TW-1:0] acc_tag = '0;
    logic sys_evt = 1'b0;
    logic commit_req;
    logic [1:0] commit_id;
    logic commit_ack = 1'b0;
    logic resp_valid, resp_hit, resp_wb;
    logic [1:0] resp_way;
    logic [TW-1:0] resp_wb_tag;
    logic [1:0] resp_epoch, cur_epoch, old_epoch;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state.
    int mv [S][W];
    int md [S][W];
    int me [S][W];
    int mt [S][W];
    int mrr [S];
    int mcnt [3];
    int mcur = 1;
    int mold = 2;
    bit msys = 0;

    always #2.5 clk = ~clk;

    ckpt_epoch_ctrl #(.SETS(S), .WAYS(W), .TAG_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_set(acc_set), .acc_tag(acc_tag),
        .sys_evt(sys_evt), .commit_req(commit_req), .commit_id(commit_id),
        .commit_ack(commit_ack), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_way(resp_way), .resp_wb(resp_wb), .resp_wb_tag(resp_wb_tag),
        .resp_epoch(resp_epoch), .cur_epoch(cur_epoch), .old_epoch(old_epoch)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Tag-walk engine model: acknowledge two cycles after a request.
    initial begin
        forever begin
            @(negedge clk);
            if (commit_req) begin
                repeat (2) @(negedge clk);
                commit_ack = 1'b1;
                @(negedge clk);
                commit_ack = 1'b0;
            end
        end
    end

    function automatic int m_hit(input int s, input int tg);
        for (int w = 0; w < W; w++) if (mv[s][w] != 0 && mt[s][w] == tg) return w;
        return -1;
    endfunction

    // Which commit the requirements call for before this access (0 = none).
    function automatic int m_need(input bit active, input bit wr, input int s,
                                  input int tg, output string why);
        int hw, own;
        bit anyns;
        why = "";
        if (msys) begin why = "R11"; return 3; end
        if (mcnt[mcur] >= HALF) begin why = "R7"; return mold; end
        if (!active) return 0;
        hw = m_hit(s, tg);
        own = 0;
        anyns = 0;
        for (int w = 0; w < W; w++) begin
            if (me[s][w] == mcur) own++;
            if (me[s][w] == 0) anyns = 1;
        end
        if (!wr) begin
            if (hw < 0 && !anyns) begin why = "R9"; return mold; end
        end else if (hw >= 0) begin
            if (me[s][hw] == mold) begin why = "R6"; return mold; end
            if (me[s][hw] == 0 && own >= CAP) begin why = "R10"; return mold; end
        end else begin
            if (own >= CAP) begin why = "R10"; return mold; end
            if (!anyns) begin why = "R9"; return mold; end
        end
        return 0;
    endfunction

    task automatic m_commit(input int mask);
        int t;
        for (int s = 0; s < S; s++)
            for (int w = 0; w < W; w++)
                if ((me[s][w] & mask) != 0) me[s][w] = 0;
        if ((mask & 1) != 0) mcnt[1] = 0;
        if ((mask & 2) != 0) mcnt[2] = 0;
        if (mask == 3) msys = 0;
        else begin t = mcur; mcur = mold; mold = t; end
    endtask

    // Wait for the expected commit, check it, let the engine finish it.
    task automatic handle_commit(input int exp, input string why);
        bit got;
        got = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (commit_req) begin got = 1; break; end
        end
        chk(got, why, "commit_req raised", int'(commit_req), 1);
        chk(commit_id == exp[1:0], why, "commit_id", int'(commit_id), exp);
        chk(!acc_ready, "R12", "acc_ready low during commit", int'(acc_ready), 0);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!commit_req) break;
        end
        m_commit(exp);
        chk(cur_epoch == mcur[1:0] && old_epoch == mold[1:0], why, "epoch roles",
            int'({cur_epoch, old_epoch}), (mcur << 2) | mold);
    endtask

    task automatic settle();
        string why;
        int ex;
        ex = m_need(0, 0, 0, 0, why);
        if (ex != 0) handle_commit(ex, why);
    endtask

    // One access from a falling edge; response checked one edge later.
    task automatic access(input bit wr, input int s, input int tg);
        string why, tagr;
        int ex, hw, v, ewb, ewt, eep, ehit, eway;
        bit saw_old;
        saw_old = 0;
        acc_valid = 1'b1;
        acc_write = wr;
        acc_set = s[1:0];
        acc_tag = tg[TW-1:0];
        for (int k = 0; k < 4; k++) begin
            #1;
            ex = m_need(1, wr, s, tg, why);
            if (ex == 0) break;
            if (why == "R6") saw_old = 1;
            handle_commit(ex, why);
        end
        chk(acc_ready, "R12", "acc_ready for access", int'(acc_ready), 1);
        hw = m_hit(s, tg);
        ewt = tg;
        if (hw >= 0) begin
            ehit = 1;
            eway = hw;
            if (wr) begin
                ewb = (me[s][hw] == 0 && md[s][hw] != 0) ? 1 : 0;
                tagr = (me[s][hw] == mcur) ? "R5" : (saw_old ? "R6" : "R4");
                if (me[s][hw] == 0) mcnt[mcur]++;
                me[s][hw] = mcur;
                md[s][hw] = 1;
                eep = mcur;
            end else begin
                ewb = 0;
                eep = me[s][hw];
                tagr = "R3";
            end
        end else begin
            ehit = 0;
            v = -1;
            for (int w = 0; w < W; w++) if (v < 0 && mv[s][w] == 0) v = w;
            if (v < 0) begin
                for (int i = 0; i < W; i++) begin
                    int j;
                    j = (mrr[s] + i) % W;
                    if (v < 0 && me[s][j] == 0) v = j;
                end
                mrr[s] = (v + 1) % W;
            end
            eway = v;
            ewb = (mv[s][v] != 0 && md[s][v] != 0) ? 1 : 0;
            ewt = mt[s][v];
            mv[s][v] = 1;
            md[s][v] = wr ? 1 : 0;
            me[s][v] = wr ? mcur : 0;
            mt[s][v] = tg;
            if (wr) mcnt[mcur]++;
            eep = wr ? mcur : 0;
            tagr = wr ? "R4" : "R3";
        end
        @(negedge clk);
        acc_valid = 1'b0;
        chk(resp_valid, "R12", "resp_valid one edge later", int'(resp_valid), 1);
        chk(resp_hit == ehit[0], tagr, "resp_hit", int'(resp_hit), ehit);
        chk(resp_way == eway[1:0], ehit ? tagr : "R8", "resp_way", int'(resp_way), eway);
        chk(resp_wb == ewb[0], ewb ? "R2" : tagr, "resp_wb", int'(resp_wb), ewb);
        if (ewb != 0)
            chk(resp_wb_tag == ewt[TW-1:0], tagr, "resp_wb_tag", int'(resp_wb_tag), ewt);
        chk(resp_epoch == eep[1:0], (eep == 0) ? "R1" : tagr, "resp_epoch",
            int'(resp_epoch), eep);
        settle();
    endtask

    task automatic do_sys();
        sys_evt = 1'b1;
        @(negedge clk);
        sys_evt = 1'b0;
        msys = 1;
        settle();
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int s = 0; s < S; s++) begin
            mrr[s] = 0;
            for (int w = 0; w < W; w++) begin
                mv[s][w] = 0; md[s][w] = 0; me[s][w] = 0; mt[s][w] = 0;
            end
        end
        mcnt[0] = 0; mcnt[1] = 0; mcnt[2] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R12: reset state.
        chk(cur_epoch == 2'b01, "R1", "reset cur_epoch", int'(cur_epoch), 1);
        chk(old_epoch == 2'b10, "R1", "reset old_epoch", int'(old_epoch), 2);
        chk(acc_ready, "R12", "reset acc_ready", int'(acc_ready), 1);
        chk(!commit_req, "R12", "reset commit_req", int'(commit_req), 0);
        chk(!resp_valid, "R12", "reset resp_valid", int'(resp_valid), 0);

        // R3 and R8: fills of invalid ways, a hit, then pointer wrap.
        for (int t = 0; t < 9; t++) access(0, 0, t);
        access(0, 0, 8);
        for (int s = 1; s < S; s++) for (int t = 0; t < 3; t++) access(0, s, t);

        // R4, R5, R2: write miss, repeat write, write to a clean committed line.
        access(1, 1, 9);
        access(1, 1, 9);
        access(1, 1, 0);
        // R10: a third line for one identifier in a set.
        access(1, 1, 1);
        // R6: write to a line of the older epoch.
        access(1, 1, 9);
        // R9: make set 2 fully speculative, then miss in it.
        access(1, 2, 4);
        access(1, 2, 5);
        access(1, 2, 6);
        access(1, 2, 7);
        access(0, 2, 12);
        access(1, 2, 13);

        // R11: both epochs committed; then R7: count threshold across all sets.
        do_sys();
        for (int s = 0; s < S; s++) begin
            access(1, s, 10);
            access(1, s, 11);
        end
        do_sys();

        // Pseudo-random stream over all causes.
        lfsr = 16'hACE1;
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[5:0] == 6'd0) do_sys();
            else access(lfsr[6], int'(lfsr[9:8]), int'(lfsr[12:10]));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule